// File: doc/BRIEF.md
# Local Interrupt Controller Base and Identity Registers

This block holds the identity and base configuration state of a per-core local interrupt controller. Its 64-bit base register carries three flags and an address field: bit 8 marks the bootstrap processor, bit 10 selects extended addressing mode and bit 11 enables the controller globally. Bits 12 and up hold the base address, which defaults to 0xFEE00000. Next to the base register sit a 32-bit initial identity, fixed by configuration, and an 8-bit working identity that software may overwrite while the controller runs in legacy mode.

The block also owns the small set of per-core context registers that an INIT event returns to known values: task priority, spurious vector, logical destination, destination format, error status, the 64-bit command register and a parameterised number of local vector table entries. It produces a wait-for-startup flag, which an INIT or full reset raises on every core that is not the bootstrap processor.

Software reaches all of this state through a single select/write port with a registered read path. Three side inputs act on the state directly: one designates the bootstrap processor, one applies a full reset and one applies an INIT reset.

Top module: `lic_idbase_regs`

## Requirements
- R1: After the power-on reset `rst`, the base register reads 0xFEE00800 with bit 8 equal to parameter RESET_BSP, both identities hold RESET_ID (working identity = low 8 bits), wait_sipi_o equals the inverse of RESET_BSP, and the context registers hold the INIT values of R8.
- R2: A `full_rst_i` pulse rebuilds the base register as 0xFEE00000 | bit 11 | the previous bit 8, with every other bit cleared.
- R3: A `full_rst_i` pulse reloads the working identity from the low 8 bits of the initial identity.
- R4: A base write (select 0) that changes bit 10 from 0 to 1 loads the working identity from the low 8 bits of the initial identity and stores the written value. A base write made while bit 10 is already 1 leaves the working identity alone.
- R5: Reading select 1 returns the full 32-bit initial identity when base bit 10 is 1, and the 8-bit working identity zero-extended when it is 0.
- R6: While `cfg_lock_i` is low, a write to select 1 sets the initial identity to wdata[31:0] and the working identity to wdata[7:0]. While it is high, such a write changes neither identity. A write to select 2 sets only the working identity (wdata[7:0]), whether or not the lock is set.
- R7: A `bsp_req_i` cycle sets base bit 8 to `bsp_val_i` and leaves every other base bit unchanged.
- R8: An `init_rst_i` pulse sets task priority (sel 3) to 0, spurious vector (sel 4, 8 bits) to 0xFF, logical destination (sel 5) to 0, destination format (sel 6, 4 bits) to 0xF, error status (sel 7) to 0, command (sel 8, 64 bits) to 0, and every vector table entry (sel 9 upward, 32 bits) to 0x00010000, which is the mask bit 16 alone. It leaves the base register and both identities unchanged.
- R9: An INIT or full reset sets wait_sipi_o to the inverse of base bit 8 as it stood before the pulse.
- R10: A full reset also performs every action of R8.
- R11: reg_rdata_o shows the register chosen by reg_sel_i one clock after the select is presented. Fields are zero-extended. A select with no register behind it reads 0. A register write in a cycle with `full_rst_i` or `init_rst_i` high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| full_rst_i | input | 1 | Full device reset pulse |
| init_rst_i | input | 1 | INIT reset pulse |
| cfg_lock_i | input | 1 | High once configuration is locked; blocks initial-identity writes |
| bsp_req_i | input | 1 | Apply bsp_val_i to the bootstrap flag |
| bsp_val_i | input | 1 | New bootstrap flag value |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | SEL_W | Register select (0 base, 1 identity, 2 working identity, 3..8 context, 9.. vector table) |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Registered read data |
| cur_id_o | output | 8 | Working identity |
| wait_sipi_o | output | 1 | Waiting-for-startup flag |

## Verification
The hardest situation to reach is a working identity that differs from the low byte of the initial identity at the moment of a mode switch or full reset. An initial-identity write always makes the two agree. The bench therefore first writes a new working identity through select 2 and only then flips bit 10 or pulses the full reset, so that a restore from the wrong source becomes visible. The same applies to the wait flag, which follows the bootstrap flag: the bench drives the designate input into both states before each INIT and full reset, and checks that the flag stays asserted when a full reset has left the bootstrap flag cleared.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BSP_BIT = 8;
  localparam int EXT_BIT = 10;
  localparam int EN_BIT  = 11;
  localparam logic [63:0] DEF_BASE = 64'h0000_0000_FEE0_0000;
  localparam int LVT_MASK_BIT = 16;
  localparam logic [31:0] LVT_RST = 32'h0001_0000;
  localparam logic [7:0] SPUR_RST = 8'hFF;
  localparam logic [3:0] DFMT_RST = 4'hF;

  localparam int SEL_BASE  = 0;
  localparam int SEL_ID    = 1;
  localparam int SEL_WID   = 2;
  localparam int SEL_TPR   = 3;
  localparam int SEL_SPUR  = 4;
  localparam int SEL_LDEST = 5;
  localparam int SEL_DFMT  = 6;
  localparam int SEL_ESR   = 7;
  localparam int SEL_ICR   = 8;
  localparam int SEL_LVT0  = 9;
endpackage

// File: rtl/lic_base_id.sv
module lic_base_id import lic_pkg::*; #(
  parameter logic [31:0] RESET_ID  = 32'h0000_0123,
  parameter bit          RESET_BSP = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        full_rst,
  input  logic        wr_base,
  input  logic        wr_id,
  input  logic        wr_wid,
  input  logic        id_locked,
  input  logic        bsp_req,
  input  logic        bsp_val,
  input  logic [63:0] wdata,
  output logic [63:0] base_q,
  output logic [31:0] init_id_q,
  output logic [7:0]  work_id_q
);
  localparam logic [63:0] EN_MASK  = 64'd1 << EN_BIT;
  localparam logic [63:0] BSP_MASK = 64'd1 << BSP_BIT;

  logic [63:0] base_nx;
  logic        ext_rise;

  always_comb begin
    base_nx = wr_base ? wdata : base_q;
    if (bsp_req) base_nx[BSP_BIT] = bsp_val;
  end

  assign ext_rise = wr_base && !base_q[EXT_BIT] && wdata[EXT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= DEF_BASE | EN_MASK | (RESET_BSP ? BSP_MASK : 64'd0);
      init_id_q <= RESET_ID;
      work_id_q <= RESET_ID[7:0];
    end else if (full_rst) begin
      base_q    <= DEF_BASE | EN_MASK | (base_q & BSP_MASK);
      work_id_q <= init_id_q[7:0];
    end else begin
      base_q <= base_nx;
      if (ext_rise) begin
        work_id_q <= init_id_q[7:0];
      end else if (wr_id && !id_locked) begin
        init_id_q <= wdata[31:0];
        work_id_q <= wdata[7:0];
      end else if (wr_wid) begin
        work_id_q <= wdata[7:0];
      end
    end
  end
endmodule

// File: rtl/lic_init_ctx.sv
module lic_init_ctx import lic_pkg::*; #(
  parameter int  NUM_LVT   = 6,
  parameter int  SEL_W     = 4,
  parameter bit  RESET_BSP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    bsp_now,
  input  logic                    we,
  input  logic [SEL_W-1:0]        sel,
  input  logic [63:0]             wdata,
  output logic [7:0]              tpr_q,
  output logic [7:0]              spur_q,
  output logic [7:0]              ldest_q,
  output logic [3:0]              dfmt_q,
  output logic [31:0]             esr_q,
  output logic [63:0]             icr_q,
  output logic [NUM_LVT-1:0][31:0] lvt_q,
  output logic                    wait_q
);
  logic [NUM_LVT-1:0] lvt_hit;

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt_dec
    assign lvt_hit[g] = we && (sel == SEL_W'(SEL_LVT0 + g));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tpr_q   <= '0;
      spur_q  <= SPUR_RST;
      ldest_q <= '0;
      dfmt_q  <= DFMT_RST;
      esr_q   <= '0;
      icr_q   <= '0;
      for (int i = 0; i < NUM_LVT; i++) lvt_q[i] <= LVT_RST;
    end else begin
      if (we && sel == SEL_W'(SEL_TPR))   tpr_q   <= wdata[7:0];
      if (we && sel == SEL_W'(SEL_SPUR))  spur_q  <= wdata[7:0];
      if (we && sel == SEL_W'(SEL_LDEST)) ldest_q <= wdata[7:0];
      if (we && sel == SEL_W'(SEL_DFMT))  dfmt_q  <= wdata[3:0];
      if (we && sel == SEL_W'(SEL_ESR))   esr_q   <= wdata[31:0];
      if (we && sel == SEL_W'(SEL_ICR))   icr_q   <= wdata;
      for (int i = 0; i < NUM_LVT; i++) begin
        if (lvt_hit[i]) lvt_q[i] <= wdata[31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        wait_q <= !RESET_BSP;
    else if (clear) wait_q <= !bsp_now;
  end
endmodule

// File: rtl/lic_rd_mux.sv
module lic_rd_mux import lic_pkg::*; #(
  parameter int NUM_LVT = 6,
  parameter int SEL_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEL_W-1:0]         sel,
  input  logic [63:0]              base_q,
  input  logic [31:0]              init_id_q,
  input  logic [7:0]               work_id_q,
  input  logic [7:0]               tpr_q,
  input  logic [7:0]               spur_q,
  input  logic [7:0]               ldest_q,
  input  logic [3:0]               dfmt_q,
  input  logic [31:0]              esr_q,
  input  logic [63:0]              icr_q,
  input  logic [NUM_LVT-1:0][31:0] lvt_q,
  output logic [63:0]              rdata_q
);
  logic [63:0] mux;

  always_comb begin
    mux = '0;
    if (sel == SEL_W'(SEL_BASE)) mux = base_q;
    if (sel == SEL_W'(SEL_ID))
      mux = base_q[EXT_BIT] ? {32'd0, init_id_q} : {56'd0, work_id_q};
    if (sel == SEL_W'(SEL_WID))   mux = {56'd0, work_id_q};
    if (sel == SEL_W'(SEL_TPR))   mux = {56'd0, tpr_q};
    if (sel == SEL_W'(SEL_SPUR))  mux = {56'd0, spur_q};
    if (sel == SEL_W'(SEL_LDEST)) mux = {56'd0, ldest_q};
    if (sel == SEL_W'(SEL_DFMT))  mux = {60'd0, dfmt_q};
    if (sel == SEL_W'(SEL_ESR))   mux = {32'd0, esr_q};
    if (sel == SEL_W'(SEL_ICR))   mux = icr_q;
    for (int i = 0; i < NUM_LVT; i++) begin
      if (sel == SEL_W'(SEL_LVT0 + i)) mux = {32'd0, lvt_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mux;
  end
endmodule

// File: rtl/lic_idbase_regs.sv
module lic_idbase_regs import lic_pkg::*; #(
  parameter int          NUM_LVT   = 6,
  parameter logic [31:0] RESET_ID  = 32'h0000_0123,
  parameter bit          RESET_BSP = 1'b1,
  parameter int          SEL_W     = $clog2(SEL_LVT0 + NUM_LVT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_rst_i,
  input  logic             init_rst_i,
  input  logic             cfg_lock_i,
  input  logic             bsp_req_i,
  input  logic             bsp_val_i,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [63:0]      reg_wdata_i,
  output logic [63:0]      reg_rdata_o,
  output logic [7:0]       cur_id_o,
  output logic             wait_sipi_o
);
  logic                     we_eff;
  logic [63:0]              base_q;
  logic [31:0]              init_id_q;
  logic [7:0]               work_id_q;
  logic [7:0]               tpr_q, spur_q, ldest_q;
  logic [3:0]               dfmt_q;
  logic [31:0]              esr_q;
  logic [63:0]              icr_q;
  logic [NUM_LVT-1:0][31:0] lvt_q;

  assign we_eff = reg_we_i && !full_rst_i && !init_rst_i;

  lic_base_id #(.RESET_ID(RESET_ID), .RESET_BSP(RESET_BSP)) base_u (
    .clk(clk), .rst(rst), .full_rst(full_rst_i),
    .wr_base(we_eff && reg_sel_i == SEL_W'(SEL_BASE)),
    .wr_id(we_eff && reg_sel_i == SEL_W'(SEL_ID)),
    .wr_wid(we_eff && reg_sel_i == SEL_W'(SEL_WID)),
    .id_locked(cfg_lock_i), .bsp_req(bsp_req_i), .bsp_val(bsp_val_i),
    .wdata(reg_wdata_i), .base_q(base_q), .init_id_q(init_id_q),
    .work_id_q(work_id_q)
  );

  lic_init_ctx #(.NUM_LVT(NUM_LVT), .SEL_W(SEL_W), .RESET_BSP(RESET_BSP)) ctx_u (
    .clk(clk), .rst(rst), .clear(full_rst_i || init_rst_i),
    .bsp_now(base_q[BSP_BIT]), .we(we_eff), .sel(reg_sel_i),
    .wdata(reg_wdata_i), .tpr_q(tpr_q), .spur_q(spur_q), .ldest_q(ldest_q),
    .dfmt_q(dfmt_q), .esr_q(esr_q), .icr_q(icr_q), .lvt_q(lvt_q),
    .wait_q(wait_sipi_o)
  );

  lic_rd_mux #(.NUM_LVT(NUM_LVT), .SEL_W(SEL_W)) rd_u (
    .clk(clk), .rst(rst), .sel(reg_sel_i), .base_q(base_q),
    .init_id_q(init_id_q), .work_id_q(work_id_q), .tpr_q(tpr_q),
    .spur_q(spur_q), .ldest_q(ldest_q), .dfmt_q(dfmt_q), .esr_q(esr_q),
    .icr_q(icr_q), .lvt_q(lvt_q), .rdata_q(reg_rdata_o)
  );

  assign cur_id_o = work_id_q;
endmodule

// File: rtl/lic_idbase_chk.sv
module lic_idbase_chk import lic_pkg::*; #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             full_rst_i,
  input logic             init_rst_i,
  input logic             cfg_lock_i,
  input logic             bsp_req_i,
  input logic             bsp_val_i,
  input logic             reg_we_i,
  input logic [SEL_W-1:0] reg_sel_i,
  input logic [63:0]      reg_wdata_i,
  input logic [63:0]      reg_rdata_o,
  input logic [7:0]       cur_id_o,
  input logic             wait_sipi_o,
  input logic [63:0]      base_q,
  input logic [31:0]      init_id_q
);
  logic wr_base;
  assign wr_base = reg_we_i && reg_sel_i == SEL_W'(SEL_BASE) && !init_rst_i;

  // R2
  full_base_chk: assert property (@(posedge clk) disable iff (rst)
    full_rst_i |=> base_q == (DEF_BASE | (64'd1 << EN_BIT) |
                              ({63'd0, $past(base_q[BSP_BIT])} << BSP_BIT)));

  // R3
  full_id_chk: assert property (@(posedge clk) disable iff (rst)
    full_rst_i |=> cur_id_o == $past(init_id_q[7:0]));

  // R4
  ext_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_base && !full_rst_i && !base_q[EXT_BIT] && reg_wdata_i[EXT_BIT])
      |=> cur_id_o == $past(init_id_q[7:0]) && base_q[EXT_BIT]);

  // R5
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel_i == SEL_W'(SEL_ID) |=>
      reg_rdata_o == ($past(base_q[EXT_BIT]) ? {32'd0, $past(init_id_q)}
                                             : {56'd0, $past(cur_id_o)}));

  // R6
  id_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_lock_i && reg_we_i && reg_sel_i == SEL_W'(SEL_ID)) |=> $stable(init_id_q));

  // R7
  bsp_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bsp_req_i && !full_rst_i && !wr_base) |=>
      base_q[BSP_BIT] == $past(bsp_val_i) && base_q[63:9] == $past(base_q[63:9]) &&
      base_q[7:0] == $past(base_q[7:0]));

  // R9
  wait_chk: assert property (@(posedge clk) disable iff (rst)
    (init_rst_i || full_rst_i) |=> wait_sipi_o == !$past(base_q[BSP_BIT]));
endmodule

bind lic_idbase_regs lic_idbase_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .full_rst_i(full_rst_i), .init_rst_i(init_rst_i),
  .cfg_lock_i(cfg_lock_i), .bsp_req_i(bsp_req_i), .bsp_val_i(bsp_val_i),
  .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .cur_id_o(cur_id_o), .wait_sipi_o(wait_sipi_o),
  .base_q(base_q), .init_id_q(init_id_q)
);

// File: tb/lic_idbase_regs_tb_top.sv
module lic_idbase_regs_tb_top;
  localparam int SEL_W = 4;
  logic clk = 0, rst = 1;
  logic full_rst = 0, init_rst = 0, cfg_lock = 0, bsp_req = 0, bsp_val = 0;
  logic reg_we = 0;
  logic [SEL_W-1:0] reg_sel = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [7:0] cur_id;
  logic wait_sipi;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lic_idbase_regs dut_i (
    .clk(clk), .rst(rst), .full_rst_i(full_rst), .init_rst_i(init_rst),
    .cfg_lock_i(cfg_lock), .bsp_req_i(bsp_req), .bsp_val_i(bsp_val),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cur_id_o(cur_id), .wait_sipi_o(wait_sipi)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_sel = SEL_W'(sel); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int sel, output logic [63:0] v);
    @(negedge clk); reg_we = 0; reg_sel = SEL_W'(sel);
    @(posedge clk); #1 v = reg_rdata;
  endtask

  task automatic pulse(bit full);
    @(negedge clk); if (full) full_rst = 1; else init_rst = 1;
    @(negedge clk); full_rst = 0; init_rst = 0;
  endtask

  task automatic designate(bit v);
    @(negedge clk); bsp_req = 1; bsp_val = v;
    @(negedge clk); bsp_req = 0;
  endtask

  function automatic logic [63:0] rst_val(int sel);
    if (sel == 4) return 64'hFF;
    if (sel == 6) return 64'hF;
    if (sel >= 9) return 64'h1_0000;
    return 64'h0;
  endfunction

  function automatic logic [63:0] fmask(int sel, logic [63:0] d);
    if (sel == 6) return d & 64'hF;
    if (sel <= 5) return d & 64'hFF;
    if (sel == 8) return d;
    return d & 64'hFFFF_FFFF;
  endfunction

  task automatic ctx_sweep(string req);
    logic [63:0] v;
    for (int s = 3; s <= 14; s++) begin
      rd(s, v); chk(req, v, rst_val(s));
    end
  endtask

  initial begin
    logic [63:0] v;
    logic [31:0] last_id;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rd(0, v); chk("R1 base", v, 64'hFEE0_0900);
    rd(1, v); chk("R1 id", v, 64'h23);
    chk("R1 cur_id", {56'd0, cur_id}, 64'h23);
    chk("R1 wait", {63'd0, wait_sipi}, 64'd0);
    ctx_sweep("R1 ctx");

    // R11 unused select and write/readback of every context field
    rd(15, v); chk("R11 unused", v, 64'd0);
    for (int s = 3; s <= 14; s++) begin
      logic [63:0] p;
      p = 64'hA5C3_9E17_0000_0000 | (64'(s) * 64'h0101_0111);
      wr(s, p); rd(s, v); chk("R11 rdback", v, fmask(s, p));
    end

    // R6 unlocked identity writes sweep
    last_id = '0;
    for (int k = 0; k < 8; k++) begin
      last_id = (32'(k) * 32'h2468_ACE1) ^ 32'h0000_015A;
      wr(1, {32'hFFFF_FFFF, last_id});
      chk("R6 cur_id", {56'd0, cur_id}, {56'd0, last_id[7:0]});
      rd(2, v); chk("R6 wid", v, {56'd0, last_id[7:0]});
    end
    // R6 locked write ignored; working id write still allowed
    cfg_lock = 1;
    wr(1, 64'hDEAD_BEEF);
    chk("R6 locked cur_id", {56'd0, cur_id}, {56'd0, last_id[7:0]});
    wr(2, 64'h5A);
    chk("R6 wid locked", {56'd0, cur_id}, 64'h5A);
    rd(1, v); chk("R5 legacy read", v, 64'h5A);

    // R4 extended mode rise restores working id
    wr(0, 64'hFEE0_0D00);
    chk("R4 restore", {56'd0, cur_id}, {56'd0, last_id[7:0]});
    rd(0, v); chk("R4 stored", v, 64'hFEE0_0D00);
    rd(1, v); chk("R5 ext read", v, {32'd0, last_id});
    wr(2, 64'h77);
    wr(0, 64'hFEE0_0D08);
    chk("R4 no restore", {56'd0, cur_id}, 64'h77);
    wr(1, 64'h1111_2222);
    rd(1, v); chk("R6 locked ext", v, {32'd0, last_id});

    // R7 designate changes only bit 8
    designate(0); rd(0, v); chk("R7 clear", v, 64'hFEE0_0C08);
    designate(1); rd(0, v); chk("R7 set", v, 64'hFEE0_0D08);

    // R2 R3 R10 full reset with bsp=1
    wr(0, 64'hFFFF_0000_0000_0DFF);
    wr(2, 64'h99);
    pulse(1);
    rd(0, v); chk("R2 base bsp1", v, 64'hFEE0_0900);
    chk("R3 cur_id", {56'd0, cur_id}, {56'd0, last_id[7:0]});
    chk("R9 wait bsp1", {63'd0, wait_sipi}, 64'd0);
    ctx_sweep("R10 ctx");
    // full reset with bsp=0
    designate(0); wr(2, 64'h3C);
    pulse(1);
    rd(0, v); chk("R2 base bsp0", v, 64'hFEE0_0800);
    chk("R3 cur_id2", {56'd0, cur_id}, {56'd0, last_id[7:0]});
    chk("R9 wait bsp0", {63'd0, wait_sipi}, 64'd1);

    // R8 INIT reset after dirtying every context field
    designate(1);
    wr(2, 64'h42);
    for (int s = 3; s <= 14; s++) wr(s, 64'h5555_AAAA_3333_CCCC ^ 64'(s));
    pulse(0);
    ctx_sweep("R8 ctx");
    rd(0, v); chk("R8 base kept", v, 64'hFEE0_0900);
    chk("R8 id kept", {56'd0, cur_id}, 64'h42);
    chk("R9 init bsp1", {63'd0, wait_sipi}, 64'd0);
    designate(0);
    pulse(0);
    chk("R9 init bsp0", {63'd0, wait_sipi}, 64'd1);
    // R11 write dropped during INIT
    @(negedge clk); reg_we = 1; reg_sel = 4'd3; reg_wdata = 64'h55; init_rst = 1;
    @(negedge clk); reg_we = 0; init_rst = 0;
    rd(3, v); chk("R11 write dropped", v, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule